// File: doc/BRIEF.md
# Data-bus I/O decoder with guarded code-memory write port

This block sits on the load/store bus of a small CPU whose code and data live in separate address spaces. Every request is first reduced to a 17-bit offset. When bit 16 of that offset is clear, the request goes on to the data RAM port unchanged, and the RAM's read data is returned to the CPU. When bit 16 is set, the block serves the access itself from a small set of I/O registers.

The I/O registers are:
- a console byte port, with a one-entry receive holding register on the input side;
- a free-running timer that advances once per `TICK_DIV` clocks;
- a debug event register;
- an exit register that raises halt with an exit code;
- a code-memory write window.

The code-memory window stays closed until a fixed 32-bit key is written to its key register. Once open, each write to the data register produces one code-memory write at a held address. That address then advances by 4, so a program image can be streamed in with back-to-back stores.

All CPU-visible effects are combinational in the cycle of the request: read data, RAM strobe, console/debug/halt/fault/error pulses and the code-memory write strobe. State (key flag, code address, timer, receive byte) updates on the clock edge that ends the request.

Top module: `dbus_io_decode`

## Requirements
- R1: Only `addr_i[16:0]` is decoded. Offset bit 16 clear: `ram_req_o` follows `req_i`, `ram_addr_o` = `addr_i[15:0]`, `ram_we_o`/`ram_size_o`/`ram_wdata_o` mirror the request, and `rdata_o` = `ram_rdata_i`. Offset bit 16 set: `ram_req_o` stays 0.
- R2: A write to offset 0x1FC80 opens the code window when the data is 0x1337F7D1 and closes it for any other data. Reset closes it.
- R3: A write to offset 0x1FC84 loads `wdata_i[CM_ADDR_W-1:0]` into the code address, which is visible on `cm_addr_o` from the next cycle. Reset clears it to 0. No other access changes it, except R4.
- R4: A write to offset 0x1FC88 while the window is open raises `cm_we_o` in that cycle, with `cm_addr_o` = held address and `cm_wdata_o` = `wdata_i`. The address then advances by 4, wrapping modulo 2^CM_ADDR_W. While the window is closed, the same write raises no `cm_we_o` and leaves the address unchanged.
- R5: A read of offset 0x1FFF4 returns floor(N / TICK_DIV), where N is the number of rising clock edges since reset was released.
- R6: A write to offset 0x10000 pulses `con_tx_valid_o`, with `con_tx_data_o` = `wdata_i[7:0]`.
- R7: A byte on `con_rx_valid_i`/`con_rx_data_i` is captured when `con_rx_ready_o` is 1 (holder empty). A read of offset 0x10000 returns the held byte zero-extended and empties the holder. When the holder is empty, the read returns all ones.
- R8: A write to offset 0x1FFFC pulses `halt_o`, with `exit_code_o` = `wdata_i`. A write to offset 0x1FFF8 pulses `dbg_valid_o`, with `dbg_data_o` = `wdata_i`.
- R9: A read of any I/O offset other than 0x10000 and 0x1FFF4 pulses `fault_o`. A write to any I/O offset other than the six writable ones pulses `err_o` and has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request strobe |
| we_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | ADDR_W | Byte address |
| size_i | input | 2 | Access size code, passed through |
| wdata_i | input | DATA_W | Store data |
| rdata_o | output | DATA_W | Load data |
| ram_req_o | output | 1 | RAM request |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | 16 | RAM byte address |
| ram_size_o | output | 2 | RAM access size |
| ram_wdata_o | output | DATA_W | RAM write data |
| ram_rdata_i | input | DATA_W | RAM read data |
| cm_we_o | output | 1 | Code-memory write strobe |
| cm_addr_o | output | CM_ADDR_W | Code-memory write address |
| cm_size_o | output | 2 | Code-memory write size |
| cm_wdata_o | output | DATA_W | Code-memory write data |
| con_tx_valid_o | output | 1 | Console output byte strobe |
| con_tx_data_o | output | 8 | Console output byte |
| con_rx_valid_i | input | 1 | Console input byte offered |
| con_rx_data_i | input | 8 | Console input byte |
| con_rx_ready_o | output | 1 | Receive holder empty |
| dbg_valid_o | output | 1 | Debug event strobe |
| dbg_data_o | output | DATA_W | Debug event payload |
| halt_o | output | 1 | Halt request |
| exit_code_o | output | DATA_W | Exit code with halt |
| fault_o | output | 1 | Illegal I/O read |
| err_o | output | 1 | Unknown I/O write |

## Verification
The bench builds the block with `TICK_DIV` = 5 and the default 18-bit code address. With a divider this small, many timer steps, and reads on both sides of a step, fit into a short run. The 18-bit address lets the code pointer be placed at 0x3FFFC, so a single open write shows it wrapping to zero. Addresses with random bits above bit 16 confirm that only the low offset decides between RAM and I/O.

// File: rtl/dbus_io_pkg.sv
package dbus_io_pkg;
  localparam int unsigned OFS_W = 17;

  localparam logic [OFS_W-1:0] OFS_CONSOLE = 17'h10000;
  localparam logic [OFS_W-1:0] OFS_CM_KEY  = 17'h1FC80;
  localparam logic [OFS_W-1:0] OFS_CM_ADDR = 17'h1FC84;
  localparam logic [OFS_W-1:0] OFS_CM_DATA = 17'h1FC88;
  localparam logic [OFS_W-1:0] OFS_TIMER   = 17'h1FFF4;
  localparam logic [OFS_W-1:0] OFS_DEBUG   = 17'h1FFF8;
  localparam logic [OFS_W-1:0] OFS_EXIT    = 17'h1FFFC;

  localparam logic [31:0] CM_UNLOCK_KEY = 32'h1337F7D1;

  typedef enum logic [3:0] {
    TGT_RAM,
    TGT_CONSOLE,
    TGT_CM_KEY,
    TGT_CM_ADDR,
    TGT_CM_DATA,
    TGT_TIMER,
    TGT_DEBUG,
    TGT_EXIT,
    TGT_OTHER
  } io_tgt_e;
endpackage

// File: rtl/dbus_io_map.sv
module dbus_io_map
  import dbus_io_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  output io_tgt_e           tgt_o
);
  logic [OFS_W-1:0] ofs;
  logic             unused_hi;

  assign ofs       = addr_i[OFS_W-1:0];
  assign unused_hi = ^addr_i[ADDR_W-1:OFS_W];

  always_comb begin
    if (!ofs[OFS_W-1]) begin
      tgt_o = TGT_RAM;
    end else begin
      unique case (ofs)
        OFS_CONSOLE: tgt_o = TGT_CONSOLE;
        OFS_CM_KEY:  tgt_o = TGT_CM_KEY;
        OFS_CM_ADDR: tgt_o = TGT_CM_ADDR;
        OFS_CM_DATA: tgt_o = TGT_CM_DATA;
        OFS_TIMER:   tgt_o = TGT_TIMER;
        OFS_DEBUG:   tgt_o = TGT_DEBUG;
        OFS_EXIT:    tgt_o = TGT_EXIT;
        default:     tgt_o = TGT_OTHER;
      endcase
    end
  end
endmodule

// File: rtl/dbus_tick_timer.sv
module dbus_tick_timer #(
  parameter int unsigned TICK_DIV = 100,
  parameter int unsigned CNT_W    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] count_o
);
  localparam int unsigned PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (pre_q == PRE_LAST) begin
      pre_q <= '0;
      cnt_q <= cnt_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/dbus_cmem_port.sv
module dbus_cmem_port
  import dbus_io_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CM_ADDR_W = 18
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 key_wr_i,
  input  logic                 addr_wr_i,
  input  logic                 data_wr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic                 we_o,
  output logic [CM_ADDR_W-1:0] addr_o
);
  localparam logic [CM_ADDR_W-1:0] STEP = CM_ADDR_W'(4);

  logic                 open_q;
  logic [CM_ADDR_W-1:0] addr_q;

  assign we_o   = data_wr_i & open_q;
  assign addr_o = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      addr_q <= '0;
    end else begin
      if (key_wr_i) open_q <= (wdata_i == DATA_W'(CM_UNLOCK_KEY));
      if (addr_wr_i)  addr_q <= wdata_i[CM_ADDR_W-1:0];
      else if (we_o)  addr_q <= addr_q + STEP;
    end
  end
endmodule

// File: rtl/dbus_rx_hold.sv
module dbus_rx_hold (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       in_valid_i,
  input  logic [7:0] in_data_i,
  input  logic       take_i,
  output logic       valid_o,
  output logic [7:0] data_o
);
  logic       valid_q;
  logic [7:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (valid_q) begin
      if (take_i) valid_q <= 1'b0;
    end else if (in_valid_i) begin
      valid_q <= 1'b1;
      data_q  <= in_data_i;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
endmodule

// File: rtl/dbus_io_decode.sv
module dbus_io_decode
  import dbus_io_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CM_ADDR_W = 18,
  parameter int unsigned TICK_DIV  = 100
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [1:0]           size_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 ram_req_o,
  output logic                 ram_we_o,
  output logic [OFS_W-2:0]     ram_addr_o,
  output logic [1:0]           ram_size_o,
  output logic [DATA_W-1:0]    ram_wdata_o,
  input  logic [DATA_W-1:0]    ram_rdata_i,
  output logic                 cm_we_o,
  output logic [CM_ADDR_W-1:0] cm_addr_o,
  output logic [1:0]           cm_size_o,
  output logic [DATA_W-1:0]    cm_wdata_o,
  output logic                 con_tx_valid_o,
  output logic [7:0]           con_tx_data_o,
  input  logic                 con_rx_valid_i,
  input  logic [7:0]           con_rx_data_i,
  output logic                 con_rx_ready_o,
  output logic                 dbg_valid_o,
  output logic [DATA_W-1:0]    dbg_data_o,
  output logic                 halt_o,
  output logic [DATA_W-1:0]    exit_code_o,
  output logic                 fault_o,
  output logic                 err_o
);
  io_tgt_e            tgt;
  logic               wr, rd;
  logic [DATA_W-1:0]  tick_cnt;
  logic               rx_valid;
  logic [7:0]         rx_byte;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  dbus_io_map #(.ADDR_W(ADDR_W)) i_map (
    .addr_i (addr_i),
    .tgt_o  (tgt)
  );

  dbus_tick_timer #(.TICK_DIV(TICK_DIV), .CNT_W(DATA_W)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .count_o (tick_cnt)
  );

  dbus_cmem_port #(.DATA_W(DATA_W), .CM_ADDR_W(CM_ADDR_W)) i_cmem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .key_wr_i  (wr && tgt == TGT_CM_KEY),
    .addr_wr_i (wr && tgt == TGT_CM_ADDR),
    .data_wr_i (wr && tgt == TGT_CM_DATA),
    .wdata_i   (wdata_i),
    .we_o      (cm_we_o),
    .addr_o    (cm_addr_o)
  );

  dbus_rx_hold i_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (con_rx_valid_i),
    .in_data_i  (con_rx_data_i),
    .take_i     (rd && tgt == TGT_CONSOLE),
    .valid_o    (rx_valid),
    .data_o     (rx_byte)
  );

  // RAM pass-through
  assign ram_req_o   = req_i && tgt == TGT_RAM;
  assign ram_we_o    = we_i;
  assign ram_addr_o  = addr_i[OFS_W-2:0];
  assign ram_size_o  = size_i;
  assign ram_wdata_o = wdata_i;

  assign cm_size_o  = size_i;
  assign cm_wdata_o = wdata_i;

  assign con_rx_ready_o = ~rx_valid;
  assign con_tx_valid_o = wr && tgt == TGT_CONSOLE;
  assign con_tx_data_o  = wdata_i[7:0];
  assign dbg_valid_o    = wr && tgt == TGT_DEBUG;
  assign dbg_data_o     = wdata_i;
  assign halt_o         = wr && tgt == TGT_EXIT;
  assign exit_code_o    = wdata_i;

  assign fault_o = rd && !(tgt inside {TGT_RAM, TGT_CONSOLE, TGT_TIMER});
  assign err_o   = wr && (tgt inside {TGT_TIMER, TGT_OTHER});

  always_comb begin
    unique case (tgt)
      TGT_RAM:     rdata_o = ram_rdata_i;
      TGT_CONSOLE: rdata_o = rx_valid ? DATA_W'(rx_byte) : '1;
      TGT_TIMER:   rdata_o = tick_cnt;
      default:     rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dbus_io_chk.sv
module dbus_io_chk
  import dbus_io_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CM_ADDR_W = 18
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic                 we_i,
  input logic [OFS_W-1:0]     io_ofs_i,
  input logic                 ram_req_o,
  input logic                 cm_we_o,
  input logic [CM_ADDR_W-1:0] cm_addr_o,
  input logic                 con_tx_valid_o,
  input logic                 con_rx_ready_o,
  input logic                 dbg_valid_o,
  input logic                 halt_o,
  input logic                 fault_o,
  input logic                 err_o
);
  AST_RAM_IO_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && io_ofs_i[OFS_W-1]) |-> !ram_req_o); // R1

  AST_CM_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(req_i && we_i && io_ofs_i == OFS_CM_ADDR) && !cm_we_o) |=> $stable(cm_addr_o)); // R3

  AST_CM_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cm_we_o |=> cm_addr_o == $past(cm_addr_o) + CM_ADDR_W'(4)); // R4

  AST_CM_WE_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cm_we_o |-> (req_i && we_i && io_ofs_i == OFS_CM_DATA)); // R4

  AST_RX_CONSUMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && io_ofs_i == OFS_CONSOLE && !con_rx_ready_o) |=> con_rx_ready_o); // R7

  AST_FAULT_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (req_i && !we_i && io_ofs_i[OFS_W-1])); // R9

  AST_SIDE_EFFECT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cm_we_o, con_tx_valid_o, dbg_valid_o, halt_o, fault_o, err_o, ram_req_o})); // R9
endmodule

bind dbus_io_decode dbus_io_chk #(.DATA_W(DATA_W), .CM_ADDR_W(CM_ADDR_W)) i_chk (
  .io_ofs_i (addr_i[16:0]),
  .*
);

// File: tb/test_dbus_io_decode.sv
`timescale 1ns/1ps
module test_dbus_io_decode;
  import dbus_io_pkg::*;

  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CM_ADDR_W = 18;
  localparam int unsigned TICK_DIV = 5;

  logic clk_i = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic                 rst_ni = 1'b0;
  logic                 req_i = 1'b0, we_i = 1'b0;
  logic [ADDR_W-1:0]    addr_i = '0;
  logic [1:0]           size_i = 2'd2;
  logic [DATA_W-1:0]    wdata_i = '0, rdata_o, ram_wdata_o, ram_rdata_i = '0;
  logic                 ram_req_o, ram_we_o;
  logic [15:0]          ram_addr_o;
  logic [1:0]           ram_size_o, cm_size_o;
  logic                 cm_we_o;
  logic [CM_ADDR_W-1:0] cm_addr_o;
  logic [DATA_W-1:0]    cm_wdata_o, dbg_data_o, exit_code_o;
  logic                 con_tx_valid_o, con_rx_ready_o, dbg_valid_o, halt_o, fault_o, err_o;
  logic [7:0]           con_tx_data_o;
  logic                 con_rx_valid_i = 1'b0;
  logic [7:0]           con_rx_data_i = '0;

  dbus_io_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CM_ADDR_W(CM_ADDR_W), .TICK_DIV(TICK_DIV))
    i_dbus_io_decode (.*);

  int vectors = 0, fails = 0;
  int edges = 0;
  always @(posedge clk_i) if (rst_ni) edges <= edges + 1;

  // bench model
  bit                   m_open = 0;
  logic [CM_ADDR_W-1:0] m_cma = '0;
  bit                   m_rx_v = 0;
  logic [7:0]           m_rx_b = '0;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic drive(bit we, logic [31:0] a, logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; addr_i = a; wdata_i = d;
    size_i = 2'($urandom_range(0, 2)); ram_rdata_i = $urandom;
    con_rx_valid_i = 1'b0;
    #1;
  endtask

  task automatic idle();
    @(negedge clk_i);
    req_i = 1'b0; con_rx_valid_i = 1'b0;
    #1;
  endtask

  function automatic logic [31:0] io_addr(logic [16:0] ofs);
    return {15'($urandom), ofs};
  endfunction

  function automatic logic [31:0] exp_timer();
    return 32'(edges / TICK_DIV);
  endfunction

  // one I/O or RAM access with full expectation check and model update
  task automatic op(bit we, logic [31:0] a, logic [31:0] d);
    logic [16:0] ofs;
    bit known_wr, known_rd;
    ofs = a[16:0];
    drive(we, a, d);
    chk("R3 cm_addr_o", 32'(cm_addr_o), 32'(m_cma));
    if (!ofs[16]) begin
      chk("R1 ram_req_o", 32'(ram_req_o), 1);
      chk("R1 ram_addr_o", 32'(ram_addr_o), 32'(a[15:0]));
      chk("R1 ram_we_o", 32'(ram_we_o), 32'(we));
      chk("R1 ram_size_o", 32'(ram_size_o), 32'(size_i));
      if (we) chk("R1 ram_wdata_o", ram_wdata_o, d);
      else    chk("R1 rdata_o", rdata_o, ram_rdata_i);
      return;
    end
    chk("R1 ram_req_o io", 32'(ram_req_o), 0);
    known_wr = ofs inside {OFS_CONSOLE, OFS_CM_KEY, OFS_CM_ADDR, OFS_CM_DATA, OFS_DEBUG, OFS_EXIT};
    known_rd = ofs inside {OFS_CONSOLE, OFS_TIMER};
    if (we) begin
      chk("R9 err_o", 32'(err_o), 32'(!known_wr));
      chk("R6 con_tx_valid_o", 32'(con_tx_valid_o), 32'(ofs == OFS_CONSOLE));
      if (ofs == OFS_CONSOLE) chk("R6 con_tx_data_o", 32'(con_tx_data_o), 32'(d[7:0]));
      chk("R8 halt_o", 32'(halt_o), 32'(ofs == OFS_EXIT));
      if (ofs == OFS_EXIT) chk("R8 exit_code_o", exit_code_o, d);
      chk("R8 dbg_valid_o", 32'(dbg_valid_o), 32'(ofs == OFS_DEBUG));
      if (ofs == OFS_DEBUG) chk("R8 dbg_data_o", dbg_data_o, d);
      chk("R4 cm_we_o", 32'(cm_we_o), 32'(ofs == OFS_CM_DATA && m_open));
      if (ofs == OFS_CM_DATA && m_open) chk("R4 cm_wdata_o", cm_wdata_o, d);
      chk("R9 fault_o on write", 32'(fault_o), 0);
      if (ofs == OFS_CM_KEY) m_open = (d == CM_UNLOCK_KEY);
      if (ofs == OFS_CM_ADDR) m_cma = d[CM_ADDR_W-1:0];
      else if (ofs == OFS_CM_DATA && m_open) m_cma = m_cma + CM_ADDR_W'(4);
    end else begin
      chk("R9 fault_o", 32'(fault_o), 32'(!known_rd));
      chk("R9 cm_we_o on read", 32'(cm_we_o), 0);
      if (ofs == OFS_TIMER) chk("R5 timer", rdata_o, exp_timer());
      if (ofs == OFS_CONSOLE) begin
        chk("R7 console read", rdata_o, m_rx_v ? {24'h0, m_rx_b} : 32'hFFFF_FFFF);
        m_rx_v = 0;
      end
    end
  endtask

  task automatic push_rx(logic [7:0] b);
    @(negedge clk_i);
    req_i = 1'b0; con_rx_valid_i = 1'b1; con_rx_data_i = b;
    #1;
    chk("R7 con_rx_ready_o", 32'(con_rx_ready_o), 32'(!m_rx_v));
    if (!m_rx_v) begin m_rx_v = 1; m_rx_b = b; end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog R5 got %0d exp %0d", edges, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [16:0] bad_ofs [6];
    void'($urandom(32'd7331));
    bad_ofs[0] = 17'h10004; bad_ofs[1] = 17'h1FC8C; bad_ofs[2] = 17'h1FFF0;
    bad_ofs[3] = 17'h18000; bad_ofs[4] = OFS_CM_KEY; bad_ofs[5] = OFS_EXIT;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // reset state
    idle();
    chk("R7 reset ready", 32'(con_rx_ready_o), 1);
    chk("R8 reset halt_o", 32'(halt_o), 0);
    chk("R3 reset cm_addr_o", 32'(cm_addr_o), 0);
    op(0, io_addr(OFS_TIMER), 0);
    op(1, io_addr(OFS_CM_DATA), 32'hDEAD0001);            // R2: locked after reset

    // unlock, stream, re-lock
    op(1, io_addr(OFS_CM_KEY), CM_UNLOCK_KEY);
    op(1, io_addr(OFS_CM_ADDR), 32'h0000_0100);
    op(1, io_addr(OFS_CM_DATA), 32'h1111_1111);
    op(1, io_addr(OFS_CM_DATA), 32'h2222_2222);
    op(1, io_addr(OFS_CM_KEY), CM_UNLOCK_KEY ^ 32'h1); // R2: near-miss key closes
    op(1, io_addr(OFS_CM_DATA), 32'h3333_3333);
    op(1, io_addr(OFS_DEBUG), 32'h0);
    // wrap of code address
    op(1, io_addr(OFS_CM_KEY), CM_UNLOCK_KEY);
    op(1, io_addr(OFS_CM_ADDR), 32'hFFFF_FFFC);
    op(1, io_addr(OFS_CM_DATA), 32'h4444_4444);
    op(1, io_addr(OFS_DEBUG), 32'h0);
    chk("R4 wrap cm_addr_o", 32'(cm_addr_o), 0);

    // console receive
    op(0, io_addr(OFS_CONSOLE), 0);
    push_rx(8'hA5);
    push_rx(8'h5A);                                    // holder full, not taken
    op(0, io_addr(OFS_CONSOLE), 0);
    op(0, io_addr(OFS_CONSOLE), 0);

    // masking of upper address bits
    op(1, 32'hFFFE_1FFC, 32'h0000_002A);
    op(0, 32'h0002_0010, 0);
    op(1, 32'hFFFF_0000 | 32'(OFS_CONSOLE), 32'h0000_0141);

    // timer across steps
    for (int i = 0; i < 12; i++) begin
      op(0, io_addr(OFS_TIMER), 0);
      repeat (i % 4) idle();
    end

    // unknown write has no effect on code address
    op(1, io_addr(17'h1FC8C), 32'h0000_0ABC);
    op(1, io_addr(OFS_TIMER), 32'h0000_0ABC);

    for (int n = 0; n < 600; n++) begin
      int k;
      k = $urandom_range(0, 11);
      case (k)
        0: op($urandom_range(0, 1) == 1, {$urandom} & 32'hFFFE_FFFF, $urandom);
        1: op(1, io_addr(OFS_CM_KEY), ($urandom_range(0, 1) == 1) ? CM_UNLOCK_KEY : $urandom);
        2: op(1, io_addr(OFS_CM_ADDR), $urandom);
        3, 4: op(1, io_addr(OFS_CM_DATA), $urandom);
        5: op(0, io_addr(OFS_TIMER), 0);
        6: op(1, io_addr(OFS_CONSOLE), $urandom);
        7: op(0, io_addr(OFS_CONSOLE), 0);
        8: push_rx(8'($urandom));
        9: op($urandom_range(0, 1) == 1, io_addr(($urandom_range(0, 1) == 1) ? OFS_DEBUG : OFS_EXIT), $urandom);
        10: op($urandom_range(0, 1) == 1, io_addr(bad_ofs[$urandom_range(0, 5)]), $urandom);
        default: idle();
      endcase
    end

    idle();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule